// File: doc/BRIEF.md
# Write-Completion Poll Master for Serial EEPROM Buses

This block is a two-wire bus master that finds out when a serial EEPROM has finished its internal programming cycle without waiting out the worst-case write time. After a write has been handed to the memory, the block is given one request. It then issues a START and the device-select byte with the direction bit set to write, and watches the acknowledge slot. While the memory is still programming, it stays off the bus and leaves that slot high. The master then closes the attempt with a STOP, leaves the bus idle for at least one bit time, and tries again.

When an attempt is acknowledged, the select byte that was just sent counts as the first byte of the next instruction. The request says what that instruction is:
- **Write:** the byte address follows, then the block ends with STOP. The data payload is outside this block.
- **Random-address read:** the byte address follows, then a repeated START is issued, then STOP.
- **No access to the memory:** STOP follows at once.

A parameter caps the number of attempts. When the cap is reached, the block gives up and reports a timeout.

The request side uses a valid/ready handshake. A request moves in the cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the block is idle, so a request held while the block is busy waits for the block and is never lost or merged. The requester may hold `cmd_valid` as long as it likes, and it may change the fields until the transfer cycle. The status pins are plain levels plus a one-cycle `done` strobe. The bus pins are open-drain enables: a 1 pulls the line low. One bit time lasts `4*QDIV` clock cycles.

Top module: `i2cp_poll_master`

## Requirements
- R1: After reset both bus enables are 0 (lines released), `cmd_ready` is 1, `done` is 0, and `poll_count`, `ready_seen` and `timeout` are 0.
- R2: Every attempt starts from an idle bus with a START (SDA falls while SCL is high). It is followed by eight bits MSB first: `cmd_dev[6:0]` and then a 0 in the last position.
- R3: During the ninth clock of every byte the master releases SDA (`sda_oe`=0), and it takes the acknowledge from SDA while SCL is high. Low means acknowledged.
- R4: A non-acknowledged attempt below the cap ends with STOP. The bus then stays released for at least `4*QDIV` cycles before the next START.
- R5: Request code 0 (write): after an acknowledged select, the master sends `cmd_addr` MSB first and then a STOP, with no repeated START.
- R6: Request code 1 (random read): after an acknowledged select, the master sends `cmd_addr`, then exactly one repeated START, then STOP.
- R7: Request codes 2 and 3 (no memory access): after an acknowledged select, the master issues STOP with no further byte.
- R8: If `MAX_POLLS` attempts in a row are not acknowledged, the master issues STOP, sets `timeout`=1 and `ready_seen`=0, and makes no further attempt.
- R9: `poll_count` equals the number of attempts made, including the acknowledged one, and never exceeds `MAX_POLLS`.
- R10: `cmd_ready` is 0 from the cycle after a request is taken until the sequence ends. A request offered meanwhile is not taken and does not change the bus traffic.
- R11: `done` pulses for one cycle after the final STOP. `ready_seen`, `addr_acked`, `timeout` and `poll_count` hold their values until the next request is taken. `addr_acked` is 1 when the address byte was acknowledged.
- R12: Apart from START, repeated START and STOP conditions, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Block idle, request taken when valid is also high |
| cmd_kind | input | 2 | Next operation: 0 write, 1 random read, 2/3 none |
| cmd_dev | input | 7 | Device-select address |
| cmd_addr | input | 8 | Byte address for the continuation |
| done | output | 1 | One-cycle strobe at the end of a sequence |
| ready_seen | output | 1 | An attempt was acknowledged |
| addr_acked | output | 1 | Byte address was acknowledged |
| timeout | output | 1 | Attempt cap reached without acknowledge |
| poll_count | output | $clog2(MAX_POLLS+1) | Number of attempts made |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |

## Verification
A wrong attempt counter or a wrong cap comparison shows up on the bus as one START too many or too few, and in `poll_count` at the `done` strobe. A sequencer that decodes the request kind wrongly shows up within one byte time after the acknowledge, as a missing or extra address byte or repeated START. A wrong bit counter or shift register shows up as corrupted select or address bytes within the same attempt. If the master drives the ninth bit, or moves SDA while SCL is high, the slave model at the bus sees it at once.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BITS, ST_STOP, ST_GAP, ST_RSTART
  } seq_st_e;

  typedef enum logic {PH_SEL, PH_ADDR} byte_ph_e;

  localparam logic [1:0] KIND_WRITE = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;
endpackage

// File: rtl/i2cp_qtick.sv
module i2cp_qtick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_spacing
      // quarter ticks never come back to back, so a bit spans 4*DIV cycles
      assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/i2cp_sync.sv
module i2cp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cp_shifter.sv
module i2cp_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         bit_o
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= din;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign bit_o = sr[W-1];

  assert_load_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(load && shift));
endmodule

// File: rtl/i2cp_poll_master.sv
module i2cp_poll_master
  import i2cp_pkg::*;
#(
  parameter int QDIV      = 50,
  parameter int MAX_POLLS = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cmd_valid,
  output logic                           cmd_ready,
  input  logic [1:0]                     cmd_kind,
  input  logic [6:0]                     cmd_dev,
  input  logic [7:0]                     cmd_addr,
  output logic                           done,
  output logic                           ready_seen,
  output logic                           addr_acked,
  output logic                           timeout,
  output logic [$clog2(MAX_POLLS+1)-1:0] poll_count,
  output logic                           scl_oe,
  output logic                           sda_oe,
  input  logic                           sda_in
);
  localparam int BYTE_W   = 8;
  localparam int PCW      = $clog2(MAX_POLLS + 1);
  localparam int BCW      = $clog2(BYTE_W + 1);
  localparam logic [BCW-1:0] ACK_SLOT = BCW'(BYTE_W);
  localparam logic [PCW-1:0] CAP      = PCW'(MAX_POLLS);

  seq_st_e        st;
  byte_ph_e       ph;
  logic [1:0]     q;
  logic [BCW-1:0] bitcnt;
  logic [1:0]     kind_r;
  logic [6:0]     dev_r;
  logic [7:0]     addr_r;
  logic           retry, ack_r;
  logic           tick, sda_s, tx_bit;
  logic           ld, sh;
  logic [7:0]     ld_val;
  logic           scl_nx, sda_nx;

  i2cp_qtick #(.DIV(QDIV)) u_tick (
    .clk(clk), .rst(rst), .en(st != ST_IDLE), .tick(tick));

  i2cp_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(sda_in), .q(sda_s));

  i2cp_shifter #(.W(BYTE_W)) u_sh (
    .clk(clk), .rst(rst), .load(ld), .din(ld_val), .shift(sh), .bit_o(tx_bit));

  assign cmd_ready = (st == ST_IDLE);

  wire phase_end = tick && (q == 2'd3);
  wire byte_end  = phase_end && (st == ST_BITS) && (bitcnt == ACK_SLOT);

  // shifter controls: select byte at the end of START, address after a taken select
  always_comb begin
    ld     = 1'b0;
    ld_val = {dev_r, 1'b0};
    sh     = phase_end && (st == ST_BITS) && (bitcnt != ACK_SLOT);
    if (phase_end && st == ST_START) ld = 1'b1;
    if (byte_end && ph == PH_SEL && ack_r && !kind_r[1]) begin
      ld     = 1'b1;
      ld_val = addr_r;
    end
  end

  // next bus enables; quarter 0 keeps SDA so it never moves with the SCL fall
  always_comb begin
    scl_nx = 1'b0;
    sda_nx = sda_oe;
    unique case (st)
      ST_START:  sda_nx = (q >= 2'd2);
      ST_BITS: begin
        scl_nx = (q < 2'd2);
        if (q != 2'd0) sda_nx = (bitcnt == ACK_SLOT) ? 1'b0 : ~tx_bit;
      end
      ST_RSTART: begin
        scl_nx = (q < 2'd2);
        sda_nx = (q == 2'd3);
      end
      ST_STOP: begin
        scl_nx = (q < 2'd2);
        if (q != 2'd0) sda_nx = (q != 2'd3);
      end
      default:   sda_nx = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      scl_oe <= scl_nx;
      sda_oe <= sda_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      ph         <= PH_SEL;
      q          <= '0;
      bitcnt     <= '0;
      kind_r     <= '0;
      dev_r      <= '0;
      addr_r     <= '0;
      retry      <= 1'b0;
      ack_r      <= 1'b0;
      done       <= 1'b0;
      ready_seen <= 1'b0;
      addr_acked <= 1'b0;
      timeout    <= 1'b0;
      poll_count <= '0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        q <= '0;
        if (cmd_valid) begin
          kind_r     <= cmd_kind;
          dev_r      <= cmd_dev;
          addr_r     <= cmd_addr;
          ready_seen <= 1'b0;
          addr_acked <= 1'b0;
          timeout    <= 1'b0;
          poll_count <= '0;
          st         <= ST_START;
        end
      end else if (tick) begin
        q <= q + 1'b1;
        if (st == ST_BITS && q == 2'd2 && bitcnt == ACK_SLOT) ack_r <= ~sda_s;
        if (q == 2'd3) begin
          unique case (st)
            ST_START: begin
              bitcnt     <= '0;
              ph         <= PH_SEL;
              poll_count <= poll_count + 1'b1;
              st         <= ST_BITS;
            end
            ST_BITS: begin
              if (bitcnt != ACK_SLOT) begin
                bitcnt <= bitcnt + 1'b1;
              end else if (ph == PH_SEL) begin
                retry <= 1'b0;
                if (ack_r) begin
                  ready_seen <= 1'b1;
                  if (kind_r[1]) begin
                    st <= ST_STOP;
                  end else begin
                    ph     <= PH_ADDR;
                    bitcnt <= '0;
                  end
                end else begin
                  st <= ST_STOP;
                  if (poll_count == CAP) timeout <= 1'b1;
                  else                   retry   <= 1'b1;
                end
              end else begin
                addr_acked <= ack_r;
                retry      <= 1'b0;
                st         <= (kind_r == KIND_READ) ? ST_RSTART : ST_STOP;
              end
            end
            ST_RSTART: st <= ST_STOP;
            ST_STOP: begin
              if (retry) begin
                st <= ST_GAP;
              end else begin
                st   <= ST_IDLE;
                done <= 1'b1;
              end
            end
            ST_GAP:  st <= ST_START;
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // SDA released for the acknowledge slot while SCL is high
  assert_ack_release_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BITS && bitcnt == ACK_SLOT && q == 2'd2) |-> !sda_oe);

  // with SCL released on both cycles, an SDA move belongs to a bus condition
  assert_sda_move_R12: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> ($past(st) inside {ST_START, ST_STOP, ST_RSTART}));

  assert_poll_cap_R9: assert property (@(posedge clk) disable iff (rst)
    poll_count <= CAP);

  assert_timeout_cap_R8: assert property (@(posedge clk) disable iff (rst)
    timeout |-> (poll_count == CAP && !ready_seen));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
endmodule

// File: tb/tb_i2cp_poll_master.sv
`timescale 1ns/1ps
module tb_i2cp_poll_master;
  localparam int QDIV = 4;
  localparam int MAXP = 5;
  localparam int PCW  = $clog2(MAXP + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_kind = '0;
  logic [6:0] cmd_dev = '0;
  logic [7:0] cmd_addr = '0;
  logic done, ready_seen, addr_acked, timeout;
  logic [PCW-1:0] poll_count;
  logic scl_oe, sda_oe, sda_in;
  logic pull = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_in = ~sda_oe & ~pull;

  i2cp_poll_master #(.QDIV(QDIV), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_dev(cmd_dev), .cmd_addr(cmd_addr),
    .done(done), .ready_seen(ready_seen), .addr_acked(addr_acked),
    .timeout(timeout), .poll_count(poll_count),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in));

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;

  // slave model and bus monitor state
  int busy_left = 0;
  bit addr_ack_en = 1'b1;
  int n_st = 0, n_sp = 0, n_rs = 0, nb = 0, bitn = 0, byte_ix = 0;
  int stop_t = 0, gap_bad = 0, ack_drv = 0, sda_hi_moves = 0;
  bit had_stop = 1'b0, in_frame = 1'b0, pscl = 1'b1, psda = 1'b1;
  logic [7:0] shreg = '0;
  logic [7:0] bytes [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    bit scl, sda;
    if (!rst) begin
      scl = ~scl_oe;
      sda = ~sda_oe & ~pull;
      if (pscl && scl && psda && !sda) begin
        if (in_frame) n_rs++;
        else begin
          n_st++;
          if (had_stop && (cyc - stop_t) < 4*QDIV) gap_bad++;
        end
        in_frame = 1'b1; bitn = 0; byte_ix = 0;
      end else if (pscl && scl && !psda && sda) begin
        n_sp++; in_frame = 1'b0; stop_t = cyc; had_stop = 1'b1;
      end else if (pscl && scl && psda != sda) begin
        sda_hi_moves++;
      end
      if (!pscl && scl && in_frame) begin
        if (bitn < 8) shreg = {shreg[6:0], sda};
        else if (sda_oe) ack_drv++;
        bitn++;
      end
      if (pscl && !scl && in_frame) begin
        if (bitn == 8) begin
          bytes[nb] = shreg; nb++;
          if (byte_ix == 0) begin
            if (busy_left == 0) pull = 1'b1;
            else busy_left--;
          end else pull = addr_ack_en;
          byte_ix++;
        end else if (bitn == 9) begin
          pull = 1'b0; bitn = 0;
        end
      end
      pscl = ~scl_oe;
      psda = ~sda_oe & ~pull;
    end
  end

  task automatic run_txn(input logic [1:0] kind, input logic [6:0] dev,
                         input logic [7:0] addr, input int busy,
                         input bit aack, input bit spur);
    int ep, eb;
    bit eacked;
    busy_left = busy; addr_ack_en = aack;
    nb = 0; n_st = 0; n_sp = 0; n_rs = 0; had_stop = 1'b0;
    gap_bad = 0; ack_drv = 0; sda_hi_moves = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = kind; cmd_dev = dev; cmd_addr = addr;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R10", "ready after take", cmd_ready, 0);
    if (spur) begin
      cmd_valid = 1'b1; cmd_kind = ~kind; cmd_dev = ~dev; cmd_addr = ~addr;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (cmd_ready) chk(1'b0, "R10", "ready while busy", 1, 0);
      end
      cmd_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    eacked = (busy < MAXP);
    ep = eacked ? busy + 1 : MAXP;
    eb = ep + ((eacked && !kind[1]) ? 1 : 0);
    chk(poll_count == PCW'(ep), "R9", "poll_count", poll_count, ep);
    chk(n_st == ep, "R2", "STARTs", n_st, ep);
    chk(n_sp == ep, "R4", "STOPs", n_sp, ep);
    chk(gap_bad == 0, "R4", "short idle gaps", gap_bad, 0);
    chk(ready_seen == eacked, "R8", "ready_seen", ready_seen, eacked);
    chk(timeout == !eacked, "R8", "timeout", timeout, !eacked);
    chk(nb == eb, kind[1] ? "R7" : "R5", "byte count", nb, eb);
    for (int i = 0; i < ep && i < nb; i++)
      chk(bytes[i] == {dev, 1'b0}, "R2", "select byte", bytes[i], {dev, 1'b0});
    if (eacked && !kind[1] && nb > ep) begin
      chk(bytes[ep] == addr, "R5", "address byte", bytes[ep], addr);
      chk(addr_acked == aack, "R11", "addr_acked", addr_acked, aack);
    end
    chk(n_rs == ((eacked && kind == 2'd1) ? 1 : 0), "R6", "repeated STARTs",
        n_rs, (eacked && kind == 2'd1) ? 1 : 0);
    chk(ack_drv == 0, "R3", "SDA driven in ack slot", ack_drv, 0);
    chk(sda_hi_moves == 0, "R12", "SDA moves with SCL high", sda_hi_moves, 0);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done width", done, 0);
    chk(poll_count == PCW'(ep) && cmd_ready, "R11", "status held", poll_count, ep);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R1", "bus released", {scl_oe, sda_oe}, 0);
    chk(cmd_ready == 1 && done == 0, "R1", "ready/done", {cmd_ready, done}, 2);
    chk(poll_count == 0 && !timeout && !ready_seen, "R1", "status clear",
        poll_count, 0);
    run_txn(2'd0, 7'h50, 8'hA5, 0, 1'b1, 1'b0);        // R5 immediate ack
    run_txn(2'd0, 7'h2B, 8'h3C, 3, 1'b1, 1'b0);        // R4 retries
    run_txn(2'd1, 7'h51, 8'h80, 2, 1'b1, 1'b0);        // R6 read
    run_txn(2'd2, 7'h7F, 8'hFF, 1, 1'b1, 1'b0);        // R7 none
    run_txn(2'd3, 7'h00, 8'h00, 0, 1'b1, 1'b0);        // R7 code 3
    run_txn(2'd0, 7'h55, 8'h01, MAXP, 1'b1, 1'b0);     // R8 cap reached
    run_txn(2'd1, 7'h2A, 8'hFE, MAXP - 1, 1'b1, 1'b0); // last attempt taken
    run_txn(2'd0, 7'h33, 8'h5A, 1, 1'b0, 1'b0);        // R11 address nack
    run_txn(2'd1, 7'h44, 8'h12, 2, 1'b1, 1'b1);        // R10 busy request
    for (int k = 0; k < 20; k++)
      run_txn(2'($urandom_range(3, 0)), 7'($urandom), 8'($urandom),
              $urandom_range(MAXP + 1, 0), 1'($urandom), 1'b0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule